// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Flag Unit

This unit sits beside a 64-bit add/subtract datapath. It forms the operand variant that the selected operation needs and adds the operands. It keeps the architectural carry and overflow status bits as state. The datapath can run in a 64-bit or a 32-bit mode. Two flag sets are produced in the same step. The mode-dependent carry and overflow bits follow the width selected by the mode input. A second carry and overflow pair always describes the low 32-bit half of the sum.

The supported operations are:
- plain add and carrying add
- subtract-from
- extended add and extended subtract-from
- add-minus-one and add-zero, both fed by the stored carry
- negate

Multiply-low and divide results are computed elsewhere. For those, the unit takes an external overflow indication and records it. A summary-overflow bit accumulates every recorded overflow. Only a direct write of the flag state clears it.

The result can be combinational or registered, selected by a parameter. The flags are always registered.

Top module: `dwflag_unit`

## Requirements
- R1: In 64-bit mode (`mode64_i`=1), a carry-setting operation loads CA with the carry out of bit 63 of the sum and CA32 with the carry out of bit 31.
- R2: In 32-bit mode (`mode64_i`=0), a carry-setting operation loads both CA and CA32 with the carry out of bit 31. Any carry out of bit 63 is ignored.
- R3: Only the carry-setting codes update CA and CA32 when `upd_en_i`=1: 1 carrying add, 2 subtract-from, 3 extended add, 4 extended subtract-from, 5 add-minus-one, 6 add-zero. Code 0 plain add, 7 negate, 8 doubleword multiply/divide and 9 word multiply/divide leave CA and CA32 unchanged.
- R4: The result by operation code is:
  - 0 and 1: A+B
  - 2: B+~A+1
  - 3: A+B+CA
  - 4: B+~A+CA
  - 5: A+all-ones+CA
  - 6: A+CA
  - 7: -A
  - 8 and 9: A unchanged

  CA is the stored carry before the operation.
- R5: With `oe_i`=1 on codes 0 to 6, OV is the signed overflow of the 64-bit sum in 64-bit mode and of the low 32-bit sum in 32-bit mode. OV32 is always the low 32-bit signed overflow.
- R6: Negate (code 7) with `oe_i`=1 sets both OV and OV32 exactly when A equals 0x8000_0000_0000_0000 in 64-bit mode, or when A[31:0] equals 0x8000_0000 in 32-bit mode. Otherwise it clears both.
- R7: Codes 8 and 9 with `oe_i`=1 load both OV and OV32 with `ext_ov_i`.
- R8: With `oe_i`=0, OV, OV32 and SO keep their values.
- R9: SO is sticky. Each overflow update ORs the new OV into SO. SO is cleared only by a flag write.
- R10: With `upd_en_i`=0 and no flag write, no flag changes.
- R11: `wr_en_i`=1 loads the flags from `wr_flags_i`, with bit 4 SO, bit 3 OV, bit 2 OV32, bit 1 CA and bit 0 CA32. The write takes priority over an operation's flag update in the same cycle.
- R12: After a synchronous reset, all five flags and the registered result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code (see R3/R4) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| oe_i | input | 1 | Overflow-enable: allow OV/OV32/SO update |
| upd_en_i | input | 1 | Flag-update enable for this operation |
| ext_ov_i | input | 1 | Overflow of an external multiply/divide result |
| wr_en_i | input | 1 | Direct write of the flag state |
| wr_flags_i | input | 5 | Flag values to write (bit order in R11) |
| result_o | output | 64 | Operation result |
| ca_o | output | 1 | Mode-dependent carry |
| ca32_o | output | 1 | Low-half carry |
| ov_o | output | 1 | Mode-dependent overflow |
| ov32_o | output | 1 | Low-half overflow |
| so_o | output | 1 | Sticky summary overflow |

## Verification
A direct flag write and an operation's flag update can land in the same cycle. The bench provokes this in directed steps with an overflowing add under OE and a carrying add. It also provokes it in the randomized stream, where writes are mixed into live traffic. It judges that the written value wins on all five bits, including SO. A second overlap is the extended operations reading the stored carry in the cycle right after another operation wrote it. Back-to-back chains of add-extended and add-zero check that each step sees its predecessor's carry.

// File: rtl/dwflag_pkg.sv
// Package: shared operation codes and flag-state layout for the dual-width
// flag unit. Assumes a 4-bit operation code; codes 10..15 are unassigned.
package dwflag_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_SUBFC  = 4'd2,
        OP_ADDE   = 4'd3,
        OP_SUBFE  = 4'd4,
        OP_ADDME  = 4'd5,
        OP_ADDZE  = 4'd6,
        OP_NEG    = 4'd7,
        OP_MD_DW  = 4'd8,
        OP_MD_W   = 4'd9
    } op_e;

    // Flag state; packed order matches the write-data bit positions.
    typedef struct packed {
        logic so;
        logic ov;
        logic ov32;
        logic ca;
        logic ca32;
    } flags_t;

    // True for operations that always write the carry pair.
    function automatic logic sets_carry(input op_e op);
        return (op == OP_ADDC)  || (op == OP_SUBFC) || (op == OP_ADDE) ||
               (op == OP_SUBFE) || (op == OP_ADDME) || (op == OP_ADDZE);
    endfunction

    // True for operations whose overflow comes from outside.
    function automatic logic ext_overflow(input op_e op);
        return (op == OP_MD_DW) || (op == OP_MD_W);
    endfunction

endpackage

// File: rtl/dwflag_operand_sel.sv
// Operand shaper: maps the operation code to the two adder inputs and
// the carry-in. Assumes the stored carry is supplied as ca_cur.
module dwflag_operand_sel
    import dwflag_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            ca_cur,
    output logic [XLEN-1:0] opa,
    output logic [XLEN-1:0] opb,
    output logic            cin
);

    // Purpose: choose inverted/constant operands and carry-in per operation.
    always_comb begin
        opa = a;
        opb = b;
        cin = 1'b0;
        case (op)
            OP_ADD, OP_ADDC: begin
                opa = a;
                opb = b;
                cin = 1'b0;
            end
            OP_SUBFC: begin
                opa = ~a;
                opb = b;
                cin = 1'b1;
            end
            OP_ADDE: begin
                opa = a;
                opb = b;
                cin = ca_cur;
            end
            OP_SUBFE: begin
                opa = ~a;
                opb = b;
                cin = ca_cur;
            end
            OP_ADDME: begin
                opa = a;
                opb = '1;
                cin = ca_cur;
            end
            OP_ADDZE: begin
                opa = a;
                opb = '0;
                cin = ca_cur;
            end
            OP_NEG: begin
                opa = ~a;
                opb = '0;
                cin = 1'b1;
            end
            OP_MD_DW, OP_MD_W: begin
                opa = a;
                opb = '0;
                cin = 1'b0;
            end
            default: begin
                opa = a;
                opb = b;
                cin = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dwflag_adder.sv
// Single full-width adder that also yields the carry and signed overflow
// at the half-width boundary. Assumes XLEN is even; HALF = XLEN/2.
module dwflag_adder #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            c_full,
    output logic            c_half,
    output logic            v_full,
    output logic            v_half
);

    localparam int HALF = XLEN / 2;

    logic [XLEN:0] wide;

    // Purpose: one carry chain for the whole word.
    always_comb begin
        wide = {1'b0, opa} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
    end

    // Purpose: recover boundary carries and signed overflows from the chain.
    always_comb begin
        sum    = wide[XLEN-1:0];
        c_full = wide[XLEN];
        c_half = wide[HALF] ^ opa[HALF] ^ opb[HALF];
        v_full = (opa[XLEN-1] == opb[XLEN-1]) && (wide[XLEN-1] != opa[XLEN-1]);
        v_half = (opa[HALF-1] == opb[HALF-1]) && (wide[HALF-1] != opa[HALF-1]);
    end

endmodule

// File: rtl/dwflag_state.sv
// Flag state: holds CA, CA32, OV, OV32 and sticky SO, choosing the
// mode-dependent and half-width values. A direct write beats any update.
module dwflag_state
    import dwflag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  op_e    op,
    input  logic   mode64,
    input  logic   oe,
    input  logic   upd_en,
    input  logic   ext_ov,
    input  logic   c_full,
    input  logic   c_half,
    input  logic   v_full,
    input  logic   v_half,
    input  logic   wr_en,
    input  flags_t wr_flags,
    output flags_t flags
);

    flags_t nxt;
    logic   ov_new;
    logic   ov32_new;
    logic   carry_op;

    // Purpose: pick the overflow pair this operation would record.
    always_comb begin
        if (ext_overflow(op)) begin
            ov_new   = ext_ov;
            ov32_new = ext_ov;
        end else if (op == OP_NEG) begin
            ov_new   = mode64 ? v_full : v_half;
            ov32_new = ov_new;
        end else begin
            ov_new   = mode64 ? v_full : v_half;
            ov32_new = v_half;
        end
    end

    // Purpose: form the next flag state from write, carry and overflow paths.
    always_comb begin
        carry_op = sets_carry(op);
        nxt      = flags;
        if (wr_en) begin
            nxt = wr_flags;
        end else if (upd_en) begin
            if (carry_op) begin
                nxt.ca   = mode64 ? c_full : c_half;
                nxt.ca32 = c_half;
            end
            if (oe) begin
                nxt.ov   = ov_new;
                nxt.ov32 = ov32_new;
                nxt.so   = flags.so | ov_new;
            end
        end
    end

    // Purpose: flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= nxt;
        end
    end

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == '0));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flags == $past(wr_flags)));

    // R9
    so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && flags.so) |=> flags.so);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !upd_en) |=> $stable(flags));

    // R3
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sets_carry(op)) |=> ($stable(flags.ca) && $stable(flags.ca32)));

    // R2
    narrow_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && upd_en && sets_carry(op) && !mode64) |=> (flags.ca == flags.ca32));

    // R8
    oe_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !oe) |=> ($stable(flags.ov) && $stable(flags.ov32) && $stable(flags.so)));

    // R7
    ext_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && upd_en && oe && ext_overflow(op))
            |=> (flags.ov == $past(ext_ov)) && (flags.ov32 == $past(ext_ov)));

endmodule

// File: rtl/dwflag_unit.sv
// Top: dual-width carry/overflow flag unit for an add/subtract datapath.
// RESULT_REG selects a registered (1) or combinational (0) result.
module dwflag_unit
    import dwflag_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit RESULT_REG = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            mode64_i,
    input  logic            oe_i,
    input  logic            upd_en_i,
    input  logic            ext_ov_i,
    input  logic            wr_en_i,
    input  logic [4:0]      wr_flags_i,
    output logic [XLEN-1:0] result_o,
    output logic            ca_o,
    output logic            ca32_o,
    output logic            ov_o,
    output logic            ov32_o,
    output logic            so_o
);

    op_e             op;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic            cin;
    logic [XLEN-1:0] sum;
    logic            c_full;
    logic            c_half;
    logic            v_full;
    logic            v_half;
    flags_t          flags;
    flags_t          wr_flags;

    // Purpose: type the raw operation code and write data.
    always_comb begin
        op       = op_e'(op_i);
        wr_flags = flags_t'(wr_flags_i);
    end

    dwflag_operand_sel #(.XLEN(XLEN)) u_sel (
        .op     (op),
        .a      (a_i),
        .b      (b_i),
        .ca_cur (flags.ca),
        .opa    (opa),
        .opb    (opb),
        .cin    (cin)
    );

    dwflag_adder #(.XLEN(XLEN)) u_add (
        .opa    (opa),
        .opb    (opb),
        .cin    (cin),
        .sum    (sum),
        .c_full (c_full),
        .c_half (c_half),
        .v_full (v_full),
        .v_half (v_half)
    );

    dwflag_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .mode64   (mode64_i),
        .oe       (oe_i),
        .upd_en   (upd_en_i),
        .ext_ov   (ext_ov_i),
        .c_full   (c_full),
        .c_half   (c_half),
        .v_full   (v_full),
        .v_half   (v_half),
        .wr_en    (wr_en_i),
        .wr_flags (wr_flags),
        .flags    (flags)
    );

    generate
        if (RESULT_REG) begin : g_res_reg
            logic [XLEN-1:0] res_q;
            // Purpose: register the result alongside the flags.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= sum;
                end
            end
            assign result_o = res_q;
        end else begin : g_res_comb
            assign result_o = sum;
        end
    endgenerate

    // Purpose: expose the flag bits.
    always_comb begin
        ca_o   = flags.ca;
        ca32_o = flags.ca32;
        ov_o   = flags.ov;
        ov32_o = flags.ov32;
        so_o   = flags.so;
    end

endmodule

// File: tb/dwflag_unit_bench.sv
`timescale 1ns/1ps
module dwflag_unit_bench;

    typedef struct {
        logic [63:0] res;
        logic [4:0]  fl;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        mode64_i = 1'b1;
    logic        oe_i = 1'b0;
    logic        upd_en_i = 1'b0;
    logic        ext_ov_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_flags_i = '0;
    logic [63:0] result_o;
    logic        ca_o, ca32_o, ov_o, ov32_o, so_o;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    item_t sb[$];
    logic [4:0] m_fl = '0;   // model: {so, ov, ov32, ca, ca32}

    always #10 clk = ~clk;   // 50 MHz

    dwflag_unit #(.XLEN(64), .RESULT_REG(1'b1)) u_dwflag_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .mode64_i(mode64_i), .oe_i(oe_i), .upd_en_i(upd_en_i),
        .ext_ov_i(ext_ov_i), .wr_en_i(wr_en_i), .wr_flags_i(wr_flags_i),
        .result_o(result_o), .ca_o(ca_o), .ca32_o(ca32_o),
        .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o)
    );

    // Driver: apply one operation and push its expected outcome.
    task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic oe, input logic m64, input logic upd, input logic xov,
                         input logic wr, input logic [4:0] wd, input string tag);
        logic [63:0] ap, bp, res;
        logic        ci, c64, c32, v64, v32, nov, nov32;
        logic [64:0] s65;
        logic [32:0] s33;
        logic signed [65:0] e64;
        logic signed [33:0] e32;
        logic [4:0]  nf;
        item_t it;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; oe_i = oe; mode64_i = m64;
        upd_en_i = upd; ext_ov_i = xov; wr_en_i = wr; wr_flags_i = wd;
        ap = a; bp = b; ci = 1'b0;
        case (op)
            4'd2: begin ap = ~a; ci = 1'b1; end
            4'd3: ci = m_fl[1];
            4'd4: begin ap = ~a; ci = m_fl[1]; end
            4'd5: begin bp = '1; ci = m_fl[1]; end
            4'd6: begin bp = '0; ci = m_fl[1]; end
            4'd7: begin ap = ~a; bp = '0; ci = 1'b1; end
            4'd8, 4'd9: bp = '0;
            default: ;
        endcase
        s65 = {1'b0, ap} + {1'b0, bp} + {64'b0, ci};
        s33 = {1'b0, ap[31:0]} + {1'b0, bp[31:0]} + {32'b0, ci};
        e64 = $signed({{2{ap[63]}}, ap}) + $signed({{2{bp[63]}}, bp}) + $signed({65'b0, ci});
        e32 = $signed({{2{ap[31]}}, ap[31:0]}) + $signed({{2{bp[31]}}, bp[31:0]}) + $signed({33'b0, ci});
        c64 = s65[64];
        c32 = s33[32];
        v64 = (e64 > 66'sd9223372036854775807) || (e64 < -66'sd9223372036854775808);
        v32 = (e32 > 34'sd2147483647) || (e32 < -34'sd2147483648);
        res = s65[63:0];
        if (op == 4'd7) begin
            res   = 64'd0 - a;
            nov   = m64 ? (a == 64'h8000_0000_0000_0000) : (a[31:0] == 32'h8000_0000);
            nov32 = nov;
        end else if (op == 4'd8 || op == 4'd9) begin
            res   = a;
            nov   = xov;
            nov32 = xov;
        end else begin
            nov   = m64 ? v64 : v32;
            nov32 = v32;
        end
        nf = m_fl;
        if (wr) begin
            nf = wd;
        end else if (upd) begin
            if (op >= 4'd1 && op <= 4'd6) begin
                nf[1] = m64 ? c64 : c32;
                nf[0] = c32;
            end
            if (oe) begin
                nf[3] = nov;
                nf[2] = nov32;
                nf[4] = m_fl[4] | nov;
            end
        end
        m_fl   = nf;
        it.res = res;
        it.fl  = nf;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare each result after the edge that registers it.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (result_o !== it.res || {so_o, ov_o, ov32_o, ca_o, ca32_o} !== it.fl) begin
                    fails++;
                    $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
                             it.tag, result_o, {so_o, ov_o, ov32_o, ca_o, ca32_o}, it.res, it.fl);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        checks++;
        if (result_o !== 64'd0 || {so_o, ov_o, ov32_o, ca_o, ca32_o} !== 5'b0) begin
            fails++;
            $display("FAIL R12 reset: got res=%h flags=%b, expected 0", result_o,
                     {so_o, ov_o, ov32_o, ca_o, ca32_o});
        end
        // R1: 64-bit carries
        drive(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 1, 0, 0, 0, "R1 full carry");
        drive(4'd1, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 1, 0, 0, 0, "R1 half carry only");
        // R2: 32-bit mode carries
        drive(4'd1, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, "R2 narrow carry");
        drive(4'd1, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 0, 0, 1, 0, 0, 0, "R2 upper carry ignored");
        // R5 / R3: plain add overflow, carry untouched
        drive(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 1, 0, 0, 0, "R1 set carry");
        drive(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 1, 0, 0, 0, "R5 R3 add ov64");
        drive(4'd0, 64'd0, 64'd0, 0, 1, 0, 0, 1, 5'b0, "R11 R9 clear");
        drive(4'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 1, 0, 1, 0, 0, 0, "R5 add ov32 narrow");
        drive(4'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 1, 1, 1, 0, 0, 0, "R5 ov32 in 64 mode");
        drive(4'd0, 64'd1, 64'd1, 1, 1, 1, 0, 0, 0, "R9 sticky so");
        drive(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 1, 0, 0, 0, "R8 oe off");
        drive(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 0, 0, 0, 0, "R10 update disabled");
        // R4: operand forms, chained through the stored carry
        drive(4'd2, 64'd5, 64'd9, 0, 1, 1, 0, 0, 0, "R4 subtract-from");
        drive(4'd3, 64'd7, 64'd8, 0, 1, 1, 0, 0, 0, "R4 extended add");
        drive(4'd4, 64'd9, 64'd5, 0, 1, 1, 0, 0, 0, "R4 extended subtract");
        drive(4'd5, 64'd0, 64'd0, 0, 1, 1, 0, 0, 0, "R4 add-minus-one");
        drive(4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 1, 1, 0, 0, 0, "R4 add-zero");
        drive(4'd6, 64'd3, 64'd0, 0, 1, 1, 0, 0, 0, "R4 add-zero chained");
        // R6: negate
        drive(4'd0, 64'd0, 64'd0, 0, 1, 0, 0, 1, 5'b0, "R11 clear");
        drive(4'd7, 64'h8000_0000_0000_0000, 64'd0, 1, 1, 1, 0, 0, 0, "R6 neg min 64");
        drive(4'd7, 64'h0000_0000_8000_0000, 64'd0, 1, 1, 1, 0, 0, 0, "R6 neg half-min in 64 mode");
        drive(4'd7, 64'h0000_0000_8000_0000, 64'd0, 1, 0, 1, 0, 0, 0, "R6 neg min 32");
        drive(4'd7, 64'd12, 64'd0, 1, 0, 1, 0, 0, 0, "R6 neg plain");
        // R7: external overflow
        drive(4'd8, 64'h1234, 64'd0, 1, 1, 1, 1, 0, 0, "R7 dword ext ov");
        drive(4'd9, 64'h5678, 64'd0, 1, 0, 1, 0, 0, 0, "R7 word no ov");
        // R11: write collides with updates
        drive(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 1, 0, 1, 5'b00110, "R11 write over ov");
        drive(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 1, 1, 0, 1, 5'b11000, "R11 write over carry");
        // Randomized mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) ra[62:0] = '1;
            if ($urandom_range(0, 3) == 0) rb[31:0] = 32'h8000_0000;
            drive(4'($urandom_range(0, 9)), ra, rb, 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 15) == 0),
                  5'($urandom_range(0, 31)), "R4 R5 random");
        end
        drive(4'd0, 64'd0, 64'd0, 0, 1, 0, 0, 0, 0, "R10 idle");
        repeat (4) @(posedge clk);
        #6;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule